// File: doc/BRIEF.md
# Read-Only I2C Slave Transmitter with Clock Stretching

This block is a 7-bit-address I2C slave that serves read transfers. It samples SCL and SDA on the system clock. Each line passes through a synchronizer and then a glitch filter. The block detects START and STOP conditions and shifts in the address byte. It acknowledges only when the address matches and the direction bit asks for a read. The slave drives both bus lines only by pulling them low.

After the address acknowledge, and after every byte the master acknowledges, the slave pulls SCL low and waits. Local logic must first write the next byte into the buffer and then request release. A release request that comes before the write in the current wait has no effect. Once released, the byte goes out most significant bit first. The slave then samples the master's acknowledge. An acknowledge leads to another wait; a missing acknowledge ends the transfer.

Local logic sees four status outputs: a direction flag, a buffer-full flag, the release bit and an interrupt flag. The interrupt flag is set at the end of every byte and stays set until it is cleared.

Top module: `i2c_read_slave`

## Requirements
- R1: After reset, scl_pd_o, sda_pd_o, irq_o, stat_rw_o, stat_full_o and rel_o are all 0.
- R2: An address byte is 7 address bits MSB first followed by a direction bit, where 1 means read. If the address equals SLAVE_ADDR and the direction bit is 1, the slave pulls SDA low during the ninth clock, sets stat_rw_o, sets stat_full_o and copies the whole address byte to buf_data_o. Any other address byte gets no acknowledge and changes no flag.
- R3: From the falling edge of the ninth SCL pulse of an acknowledged address or of an acknowledged data byte, the slave holds SCL low until a release is accepted. rel_o is 0 whenever a hold begins.
- R4: A rel_set_i pulse is accepted only if wr_buf_i was pulsed earlier in the same hold. Otherwise it is ignored, and SCL stays held with rel_o at 0. A wr_buf_i pulse outside a hold changes neither buf_data_o nor stat_full_o.
- R5: A data byte is sent MSB first. SDA changes only while SCL is low.
- R6: irq_o is set on the falling edge of the ninth SCL pulse of every acknowledged address byte and every transmitted byte. It stays at 1 until irq_clr_i is pulsed.
- R7: The master's acknowledge is sampled on the rising edge of the ninth SCL pulse. If SDA is low, the slave holds SCL again and waits for new data. If SDA is high, the slave releases both lines, clears stat_rw_o and returns to idle.
- R8: stat_full_o is set when an address is captured or data is written during a hold. It clears when the eighth bit of a byte has been shifted out.
- R9: A START (SDA falling while SCL is high) restarts address reception from any state, including mid-byte. A STOP (SDA rising while SCL is high) returns the slave to idle.
- R10: The slave leaves SDA released during the ninth clock of every transmitted byte.
- R11: A change on either line that lasts fewer than FILT_CYCLES system clocks after synchronization is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| scl_pd_o | output | 1 | 1 pulls SCL low |
| sda_pd_o | output | 1 | 1 pulls SDA low |
| wr_buf_i | input | 1 | One-cycle pulse that writes wr_data_i into the buffer |
| wr_data_i | input | 8 | Byte to transmit |
| rel_set_i | input | 1 | One-cycle request to release SCL |
| irq_clr_i | input | 1 | One-cycle pulse that clears irq_o |
| buf_data_o | output | 8 | Buffer contents (captured address or written data) |
| stat_rw_o | output | 1 | Read transfer in progress |
| stat_full_o | output | 1 | Buffer holds an unconsumed byte |
| rel_o | output | 1 | Clock-release bit |
| irq_o | output | 1 | End-of-byte interrupt flag |

## Verification
The assertions check these rules on every cycle:
- the release bit rises only after a write in the same hold;
- a hold always starts with the release bit clear;
- SDA moves only while the filtered SCL is low;
- the interrupt and the buffer-full clear line up with a filtered SCL falling edge;
- the filter output changes only after its input has disagreed with it.

Only the bench scenarios can show the rest, because each needs a complete bus transaction:
- which address bytes are acknowledged;
- the values of the transmitted bytes;
- that a stretched SCL really stalls the master;
- the ACK and NACK branches;
- recovery after a STOP or a repeated START in the middle of a byte;
- that a short glitch does not look like a START.

// File: rtl/i2cs_pkg.sv
`timescale 1ns/1ps
package i2cs_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 7;
   localparam int CNT_W  = $clog2(BYTE_W + 1);

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_HOLD,
      ST_SHIFT,
      ST_MACK,
      ST_SKIP
   } slv_state_t;
endpackage

// File: rtl/i2cs_glitch_filter.sv
`timescale 1ns/1ps
module i2cs_glitch_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_CYCLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);
   initial assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
   initial assert (FILT_CYCLES >= 0) else $error("FILT_CYCLES must not be negative");

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
   end
   assign raw = sync_q[SYNC_STAGES-1];

   generate
      if (FILT_CYCLES == 0) begin : g_bypass
         assign line_o = raw;
      end else begin : g_filt
         localparam int FCW = $clog2(FILT_CYCLES + 1);
         logic [FCW-1:0] cnt_q;
         logic           level_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q   <= '0;
               level_q <= 1'b1;
            end else if (raw == level_q) begin
               cnt_q <= '0;
            end else if (cnt_q == FCW'(FILT_CYCLES - 1)) begin
               level_q <= raw;
               cnt_q   <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         assign line_o = level_q;

         // R11: the filtered level only moves after the raw level disagreed with it
         a_r11_filter_follows: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(level_q) |-> ($past(raw) != $past(level_q)));
      end
   endgenerate
endmodule

// File: rtl/i2cs_bus_events.sv
`timescale 1ns/1ps
module i2cs_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   logic scl_prev, sda_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_prev <= scl_f;
         sda_prev <= sda_f;
      end
   end

   assign scl_rise = scl_f & ~scl_prev;
   assign scl_fall = ~scl_f & scl_prev;
   assign start_ev = scl_f & scl_prev & sda_prev & ~sda_f;
   assign stop_ev  = scl_f & scl_prev & ~sda_prev & sda_f;
endmodule

// File: rtl/i2cs_tx_engine.sv
`timescale 1ns/1ps
module i2cs_tx_engine
   import i2cs_pkg::*;
#(
   parameter logic [ADDR_W-1:0] SLAVE_ADDR = 7'h42
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_f,
   input  logic              sda_f,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_ev,
   input  logic              stop_ev,
   input  logic              wr_buf,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              rel_set,
   input  logic              irq_clr,
   output logic              scl_pd,
   output logic              sda_pd,
   output logic [BYTE_W-1:0] buf_data,
   output logic              stat_rw,
   output logic              stat_full,
   output logic              rel,
   output logic              irq
);
   slv_state_t        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-1:0] rx_sh_q, tx_sh_q, buf_q;
   logic              rw_q, full_q, rel_q, irq_q, wr_seen_q, ack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         rx_sh_q   <= '0;
         tx_sh_q   <= '1;
         buf_q     <= '0;
         rw_q      <= 1'b0;
         full_q    <= 1'b0;
         rel_q     <= 1'b0;
         irq_q     <= 1'b0;
         wr_seen_q <= 1'b0;
         ack_q     <= 1'b0;
      end else begin
         if (irq_clr) irq_q <= 1'b0;
         if (stop_ev) begin
            state_q <= ST_IDLE;
            rw_q    <= 1'b0;
            rel_q   <= 1'b0;
         end else if (start_ev) begin
            state_q <= ST_ADDR;
            cnt_q   <= '0;
            rw_q    <= 1'b0;
            rel_q   <= 1'b0;
         end else begin
            unique case (state_q)
               ST_ADDR: begin
                  if (scl_rise) begin
                     rx_sh_q <= {rx_sh_q[BYTE_W-2:0], sda_f};
                     cnt_q   <= cnt_q + 1'b1;
                  end else if (scl_fall && cnt_q == CNT_W'(BYTE_W)) begin
                     if (rx_sh_q[BYTE_W-1:1] == SLAVE_ADDR && rx_sh_q[0]) begin
                        state_q <= ST_AACK;
                        rw_q    <= 1'b1;
                        buf_q   <= rx_sh_q;
                        full_q  <= 1'b1;
                     end else begin
                        state_q <= ST_SKIP;
                     end
                  end
               end
               ST_AACK: begin
                  if (scl_fall) begin
                     state_q   <= ST_HOLD;
                     irq_q     <= 1'b1;
                     cnt_q     <= '0;
                     wr_seen_q <= 1'b0;
                     rel_q     <= 1'b0;
                  end
               end
               ST_HOLD: begin
                  if (wr_buf) begin
                     buf_q     <= wr_data;
                     tx_sh_q   <= wr_data;
                     full_q    <= 1'b1;
                     wr_seen_q <= 1'b1;
                  end else if (rel_set && wr_seen_q) begin
                     rel_q   <= 1'b1;
                     state_q <= ST_SHIFT;
                  end
               end
               ST_SHIFT: begin
                  if (scl_fall) begin
                     if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                        state_q <= ST_MACK;
                        full_q  <= 1'b0;
                     end else begin
                        tx_sh_q <= {tx_sh_q[BYTE_W-2:0], 1'b1};
                        cnt_q   <= cnt_q + 1'b1;
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     ack_q <= ~sda_f;
                  end else if (scl_fall) begin
                     irq_q <= 1'b1;
                     rel_q <= 1'b0;
                     if (ack_q) begin
                        state_q   <= ST_HOLD;
                        cnt_q     <= '0;
                        wr_seen_q <= 1'b0;
                     end else begin
                        state_q <= ST_IDLE;
                        rw_q    <= 1'b0;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign scl_pd    = (state_q == ST_HOLD);
   assign sda_pd    = (state_q == ST_AACK)
                    | ((state_q == ST_SHIFT) & ~tx_sh_q[BYTE_W-1])
                    | ((state_q == ST_HOLD) & wr_seen_q & ~tx_sh_q[BYTE_W-1]);
   assign buf_data  = buf_q;
   assign stat_rw   = rw_q;
   assign stat_full = full_q;
   assign rel       = rel_q;
   assign irq       = irq_q;

   // R4: release bit only rises once the buffer was written in this hold
   a_r4_release_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rel_q) |-> $past(wr_seen_q));
   // R3: a hold never starts with the release bit still set
   a_r3_hold_starts_unreleased: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_pd) |-> !rel_q);
   // R5: SDA drive moves only while the filtered SCL is low
   a_r5_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pd) |-> !scl_f);
   // R6: interrupt rises only after a filtered SCL falling edge
   a_r6_irq_on_scl_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> $past(scl_fall));
   // R8: buffer-full clears only at a filtered SCL falling edge
   a_r8_full_clears_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(full_q) |-> $past(scl_fall));
   // R2: address acknowledge only with the read flag and full buffer
   a_r2_ack_has_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_AACK) |-> (rw_q && full_q));
endmodule

// File: rtl/i2c_read_slave.sv
`timescale 1ns/1ps
module i2c_read_slave
   import i2cs_pkg::*;
#(
   parameter logic [ADDR_W-1:0] SLAVE_ADDR  = 7'h42,
   parameter int                SYNC_STAGES = 2,
   parameter int                FILT_CYCLES = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_pd_o,
   output logic              sda_pd_o,
   input  logic              wr_buf_i,
   input  logic [BYTE_W-1:0] wr_data_i,
   input  logic              rel_set_i,
   input  logic              irq_clr_i,
   output logic [BYTE_W-1:0] buf_data_o,
   output logic              stat_rw_o,
   output logic              stat_full_o,
   output logic              rel_o,
   output logic              irq_o
);
   localparam int N_LINES = 2;

   logic [N_LINES-1:0] lines_raw, lines_f;
   logic scl_rise, scl_fall, start_ev, stop_ev;

   assign lines_raw = {sda_i, scl_i};

   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      i2cs_glitch_filter #(
         .SYNC_STAGES(SYNC_STAGES),
         .FILT_CYCLES(FILT_CYCLES)
      ) u_filt (
         .clk    (clk),
         .rst_n  (rst_n),
         .line_i (lines_raw[i]),
         .line_o (lines_f[i])
      );
   end

   i2cs_bus_events u_events (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_f    (lines_f[0]),
      .sda_f    (lines_f[1]),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev)
   );

   i2cs_tx_engine #(
      .SLAVE_ADDR(SLAVE_ADDR)
   ) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_f     (lines_f[0]),
      .sda_f     (lines_f[1]),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_ev  (start_ev),
      .stop_ev   (stop_ev),
      .wr_buf    (wr_buf_i),
      .wr_data   (wr_data_i),
      .rel_set   (rel_set_i),
      .irq_clr   (irq_clr_i),
      .scl_pd    (scl_pd_o),
      .sda_pd    (sda_pd_o),
      .buf_data  (buf_data_o),
      .stat_rw   (stat_rw_o),
      .stat_full (stat_full_o),
      .rel       (rel_o),
      .irq       (irq_o)
   );
endmodule

// File: tb/i2c_read_slave_bench.sv
`timescale 1ns/1ps
module i2c_read_slave_bench;
   localparam int       CLK_PERIOD = 10;
   localparam int       HALF       = 40;
   localparam int       WD_CYCLES  = 150000;
   localparam bit [6:0] ADDR       = 7'h42;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl_pd = 1'b0, m_sda_pd = 1'b0;
   logic       scl_pd, sda_pd, wr_buf = 1'b0, rel_set = 1'b0, irq_clr = 1'b0;
   logic [7:0] wr_data = '0, buf_data;
   logic       stat_rw, stat_full, rel, irq;
   logic       scl_line, sda_line;
   int         checks = 0, errors = 0;
   bit         done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign scl_line = ~(m_scl_pd | scl_pd);
   assign sda_line = ~(m_sda_pd | sda_pd);

   i2c_read_slave #(.SLAVE_ADDR(ADDR)) u_i2c_read_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
      .scl_pd_o(scl_pd), .sda_pd_o(sda_pd),
      .wr_buf_i(wr_buf), .wr_data_i(wr_data), .rel_set_i(rel_set), .irq_clr_i(irq_clr),
      .buf_data_o(buf_data), .stat_rw_o(stat_rw), .stat_full_o(stat_full),
      .rel_o(rel), .irq_o(irq));

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // ---------------- bus master model ----------------
   task automatic m_scl_release();
      m_scl_pd = 1'b0;
      tick(1);
      while (!scl_line) tick(1);
   endtask

   task automatic m_start();
      m_sda_pd = 1'b1; tick(HALF);
      m_scl_pd = 1'b1; tick(HALF);
   endtask

   task automatic m_rstart();
      m_sda_pd = 1'b0; tick(HALF);
      m_scl_release(); tick(HALF);
      m_start();
   endtask

   task automatic m_stop();
      m_sda_pd = 1'b1; tick(HALF);
      m_scl_release(); tick(HALF);
      m_sda_pd = 1'b0; tick(HALF);
   endtask

   task automatic m_bit_out(input logic b);
      m_sda_pd = ~b; tick(HALF);
      m_scl_release(); tick(HALF);
      m_scl_pd = 1'b1; tick(HALF);
   endtask

   task automatic m_bit_in(output logic b);
      m_sda_pd = 1'b0; tick(HALF);
      m_scl_release(); tick(HALF/2);
      b = sda_line; tick(HALF/2);
      m_scl_pd = 1'b1; tick(HALF);
   endtask

   task automatic m_send_byte(input logic [7:0] d, output logic acked);
      logic b;
      for (int i = 7; i >= 0; i--) m_bit_out(d[i]);
      m_bit_in(b);
      acked = ~b;
   endtask

   task automatic m_read_byte(input logic give_ack, output logic [7:0] d, output logic sda_free);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         m_bit_in(b);
         d[i] = b;
      end
      sda_free = ~sda_pd;
      m_bit_out(~give_ack);
   endtask

   // ---------------- local-logic side ----------------
   task automatic h_write(input logic [7:0] d);
      wr_data = d; wr_buf = 1'b1; tick(1); wr_buf = 1'b0; tick(1);
   endtask
   task automatic h_release();
      rel_set = 1'b1; tick(1); rel_set = 1'b0; tick(1);
   endtask
   task automatic h_clear();
      irq_clr = 1'b1; tick(1); irq_clr = 1'b0; tick(1);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk("R1", "scl_pd", scl_pd, 0);
      chk("R1", "sda_pd", sda_pd, 0);
      chk("R1", "irq", irq, 0);
      chk("R1", "stat_rw", stat_rw, 0);
      chk("R1", "stat_full", stat_full, 0);
      chk("R1", "rel", rel, 0);
   endtask

   task automatic t_wrong_addr();
      logic acked;
      m_start();
      m_send_byte({ADDR ^ 7'h01, 1'b1}, acked);
      chk("R2", "ack for other address", acked, 0);
      chk("R2", "irq after other address", irq, 0);
      m_stop();
      m_start();
      m_send_byte({ADDR, 1'b0}, acked);
      chk("R2", "ack for write direction", acked, 0);
      chk("R2", "rw after write direction", stat_rw, 0);
      chk("R2", "full after write direction", stat_full, 0);
      m_stop();
   endtask

   task automatic t_read_one();
      logic acked, free;
      logic [7:0] d;
      m_start();
      m_send_byte({ADDR, 1'b1}, acked);
      chk("R2", "address ack", acked, 1);
      chk("R2", "rw flag", stat_rw, 1);
      chk("R2", "buffer holds address", buf_data, {ADDR, 1'b1});
      chk("R8", "full after address", stat_full, 1);
      chk("R6", "irq after address", irq, 1);
      chk("R3", "scl held after address", scl_pd, 1);
      chk("R3", "rel clear at hold", rel, 0);
      h_release();
      chk("R4", "early release ignored", rel, 0);
      chk("R4", "scl still held", scl_pd, 1);
      h_clear();
      chk("R6", "irq cleared", irq, 0);
      fork
         m_read_byte(1'b0, d, free);
         begin
            tick(200);
            chk("R3", "master stalled by stretch", scl_line, 0);
            h_write(8'hA5);
            chk("R4", "write alone keeps hold", scl_pd, 1);
            h_release();
            chk("R4", "release after write", rel, 1);
         end
      join
      chk("R5", "byte value", d, 8'hA5);
      chk("R10", "sda free at ninth clock", free, 1);
      chk("R7", "nack releases scl", scl_pd, 0);
      chk("R7", "nack releases sda", sda_pd, 0);
      chk("R7", "nack clears rw", stat_rw, 0);
      chk("R6", "irq after byte", irq, 1);
      chk("R8", "full cleared after shift", stat_full, 0);
      m_stop();
      h_clear();
   endtask

   task automatic t_idle_write();
      h_write(8'h77);
      chk("R4", "idle write leaves buffer", buf_data, 8'hA5);
      chk("R4", "idle write leaves full", stat_full, 0);
   endtask

   task automatic t_multi();
      logic acked, free;
      logic [7:0] d;
      m_start();
      m_send_byte({ADDR, 1'b1}, acked);
      chk("R2", "address ack", acked, 1);
      h_clear();
      h_write(8'h3C);
      h_release();
      m_read_byte(1'b1, d, free);
      chk("R5", "first byte", d, 8'h3C);
      chk("R10", "sda free at ninth clock", free, 1);
      chk("R7", "ack leads to new hold", scl_pd, 1);
      chk("R7", "rw kept after ack", stat_rw, 1);
      chk("R8", "full clear while waiting", stat_full, 0);
      chk("R6", "irq after acked byte", irq, 1);
      chk("R3", "rel clear in new hold", rel, 0);
      h_clear();
      h_write(8'hC3);
      chk("R8", "full after write", stat_full, 1);
      h_release();
      m_read_byte(1'b0, d, free);
      chk("R5", "second byte", d, 8'hC3);
      chk("R7", "nack ends transfer", scl_pd, 0);
      m_stop();
      h_clear();
   endtask

   task automatic t_glitch();
      logic acked;
      m_sda_pd = 1'b1; tick(1); m_sda_pd = 1'b0; tick(HALF);
      m_scl_pd = 1'b1; tick(HALF);
      m_send_byte({ADDR, 1'b1}, acked);
      chk("R11", "glitch is not a start", acked, 0);
      chk("R11", "no irq after glitch", irq, 0);
      m_stop();
   endtask

   task automatic t_restart();
      logic acked, free;
      logic [7:0] d;
      m_start();
      for (int i = 0; i < 4; i++) m_bit_out(1'b1);
      m_stop();
      chk("R9", "stop mid-byte idle scl", scl_pd, 0);
      chk("R9", "stop mid-byte idle sda", sda_pd, 0);
      chk("R9", "stop mid-byte no irq", irq, 0);
      m_start();
      for (int i = 0; i < 3; i++) m_bit_out(1'b0);
      m_rstart();
      m_send_byte({ADDR, 1'b1}, acked);
      chk("R9", "repeated start restarts address", acked, 1);
      h_write(8'h5A);
      h_release();
      m_read_byte(1'b0, d, free);
      chk("R9", "byte after repeated start", d, 8'h5A);
      m_stop();
      h_clear();
   endtask

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(5);
      t_reset();
      t_wrong_addr();
      t_read_one();
      t_idle_write();
      t_multi();
      t_glitch();
      t_restart();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule